// File: doc/BRIEF.md
# Windowed Watchdog Fault Detector

This block watches a heartbeat line driven by a processor and flags a fault when a service edge comes too soon after the previous one, or does not come in time. Only high-to-low transitions of the heartbeat count as service. The line is synchronised and then filtered, so that short glitches are never taken as service. Elapsed time is measured in ticks of a prescaler. Both the prescaler and the tick counter restart on every accepted edge and on every fault. A static option code selects one of eight pairs of early and late limits.

Faults leave the block as registered one-cycle pulses that go to a reset generator. A separate output names the kind of fault. The reset generator returns a reset-active level. While that level is high, the timer is held at zero and service edges are discarded. The first edge accepted after that level falls only starts the timer and is never judged early. The watchdog cannot be switched off. `opt_sel` may change only while `rst_active` is high.

Top module: `wdw_supervisor`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `wd_fault`, `fault_early` and `fault_late` are 0. After `rst` the block is unarmed, so the next accepted edge raises no early fault.
- R2: Only falling transitions of the filtered heartbeat are service events. A rising transition neither restarts the timer nor raises a fault.
- R3: The synchronised input changes the filtered level only after it has held the new value for FILT_CYC consecutive clock cycles (30 by default, 150 ns at 200 MHz). A low pulse of FILT_CYC-1 cycles is ignored. A low pulse of FILT_CYC cycles is a service event.
- R4: Let n be the number of cycles between a timer restart and the next service event. An armed service event with n <= EARLY*TICK_DIV raises `fault_early` for one cycle and restarts the timer.
- R5: A service event with EARLY*TICK_DIV < n <= LATE*TICK_DIV raises no fault and restarts the timer.
- R6: If no service event has come LATE*TICK_DIV cycles after a restart, `fault_late` pulses for one cycle and the timer restarts. Late faults therefore repeat every LATE*TICK_DIV cycles. A service event in that same cycle takes priority and counts as valid.
- R7: While `rst_active` is high, the timer is held at zero, service events are discarded and no fault is raised. The first late fault after release is visible LATE*TICK_DIV cycles after the last clock edge at which `rst_active` was high.
- R8: `rst_active` disarms the early check. The first service event after release only arms it. A fault does not disarm it.
- R9: `opt_sel` selects the limit pair {EARLY, LATE} in ticks: 0 = {3, 20}, 1 = {30, 200}, 2 = {30, 600}, 3 = {30, 20000}, 4 = {30, 120000}, 5 = {48, 88}, 6 = {82, 152}, 7 = {1536, 2480}. At the default TICK_DIV of 100000, a tick is 0.5 ms at 200 MHz.
- R10: `wd_fault` is high exactly in the cycles where `fault_early` or `fault_late` is high. The two kind outputs are never high together, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opt_sel | input | 3 | Static limit pair select |
| rst_active | input | 1 | High while the reset generator holds the system in reset |
| wdi | input | 1 | Asynchronous heartbeat line |
| wd_fault | output | 1 | One-cycle fault pulse toward the reset generator |
| fault_early | output | 1 | The pulse was an early (too fast) fault |
| fault_late | output | 1 | The pulse was a late (missing service) fault |

## Verification
The bench places service intervals exactly on both sides of the early boundary and exactly at the late boundary. A design that is off by one tick-phase would fault on a valid edge, or miss a fault on an early one. It measures the late fault to the exact cycle after release and after a previous late fault. A design that keeps its prescaler free-running, or does not restart after a fault, would drift from those cycles. It sends glitches one cycle below the filter length, rising edges, edges during the reset hold, and the first edge after a reset. A design that arms on discarded edges, or judges the first edge, would report early faults that must not appear. One interval yields a late fault followed by an early fault, which shows that arming survives a fault.

// File: rtl/wdw_pkg.sv
`timescale 1ns / 1ps
package wdw_pkg;

    localparam int AGE_W = 17;

    typedef logic [AGE_W-1:0] age_t;

    typedef struct packed {
        age_t early_lim;
        age_t late_lim;
    } win_lim_t;

    typedef enum logic [1:0] {
        VERD_NONE  = 2'd0,
        VERD_EARLY = 2'd1,
        VERD_LATE  = 2'd2
    } verdict_e;

    // Limit pair per option code, in prescaler ticks.
    function automatic win_lim_t win_limits(input logic [2:0] sel);
        win_lim_t l;
        case (sel)
            3'd0:    begin l.early_lim = age_t'(3);    l.late_lim = age_t'(20);     end
            3'd1:    begin l.early_lim = age_t'(30);   l.late_lim = age_t'(200);    end
            3'd2:    begin l.early_lim = age_t'(30);   l.late_lim = age_t'(600);    end
            3'd3:    begin l.early_lim = age_t'(30);   l.late_lim = age_t'(20000);  end
            3'd4:    begin l.early_lim = age_t'(30);   l.late_lim = age_t'(120000); end
            3'd5:    begin l.early_lim = age_t'(48);   l.late_lim = age_t'(88);     end
            3'd6:    begin l.early_lim = age_t'(82);   l.late_lim = age_t'(152);    end
            default: begin l.early_lim = age_t'(1536); l.late_lim = age_t'(2480);   end
        endcase
        return l;
    endfunction

endpackage

// File: rtl/wdw_edge_filter.sv
`timescale 1ns / 1ps
module wdw_edge_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic fall_evt
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_q;
    logic                   lvl_q;
    logic                   fall_q;
    logic                   sample;
    logic                   flip;

    // Synchroniser chain, idles high.
    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], din};
    end

    assign sample = sync_q[SYNC_STAGES-1];
    assign flip   = (sample != lvl_q) && (run_q == CW'(FILT_CYC - 1));

    // Level changes only after FILT_CYC consecutive differing samples.
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            lvl_q  <= 1'b1;
            fall_q <= 1'b0;
        end else begin
            fall_q <= flip & lvl_q;
            if (sample == lvl_q) begin
                run_q <= '0;
            end else if (flip) begin
                lvl_q <= sample;
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign fall_evt = fall_q;

endmodule

// File: rtl/wdw_tick_timer.sv
`timescale 1ns / 1ps
module wdw_tick_timer
    import wdw_pkg::*;
#(
    parameter int TICK_DIV = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick,
    output age_t age
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    age_t age_q;

    generate
        if (TICK_DIV == 1) begin : g_no_pre
            assign tick = 1'b1;
        end else begin : g_pre
            logic [PRE_W-1:0] pre_q;
            assign tick = (pre_q == PRE_W'(TICK_DIV - 1));
            always_ff @(posedge clk) begin
                if (rst || clr)  pre_q <= '0;
                else if (tick)   pre_q <= '0;
                else             pre_q <= pre_q + 1'b1;
            end
        end
    endgenerate

    // Tick count since the last restart, saturating.
    always_ff @(posedge clk) begin
        if (rst || clr)              age_q <= '0;
        else if (tick && age_q != '1) age_q <= age_q + 1'b1;
    end

    assign age = age_q;

endmodule

// File: rtl/wdw_window_judge.sv
`timescale 1ns / 1ps
module wdw_window_judge
    import wdw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hold,
    input  logic     fall_evt,
    input  logic     tick,
    input  age_t     age,
    input  win_lim_t lim,
    output logic     restart,
    output logic     armed,
    output logic     fault_early,
    output logic     fault_late,
    output logic     wd_fault
);
    logic     evt;
    logic     expire;
    logic     armed_q;
    verdict_e verdict;
    verdict_e verd_q;

    assign evt    = fall_evt & ~hold;
    assign expire = tick & (age == (lim.late_lim - 1'b1)) & ~hold;

    // A service event takes priority over a coincident expiry.
    always_comb begin
        verdict = VERD_NONE;
        if (evt) begin
            if (armed_q && (age < lim.early_lim)) verdict = VERD_EARLY;
        end else if (expire) begin
            verdict = VERD_LATE;
        end
    end

    assign restart = evt | expire;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            verd_q  <= VERD_NONE;
        end else begin
            if (hold)     armed_q <= 1'b0;
            else if (evt) armed_q <= 1'b1;
            verd_q <= verdict;
        end
    end

    assign armed       = armed_q;
    assign fault_early = (verd_q == VERD_EARLY);
    assign fault_late  = (verd_q == VERD_LATE);
    assign wd_fault    = (verd_q != VERD_NONE);

endmodule

// File: rtl/wdw_supervisor.sv
`timescale 1ns / 1ps
module wdw_supervisor
    import wdw_pkg::*;
#(
    parameter int TICK_DIV    = 100000,
    parameter int FILT_CYC    = 30,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] opt_sel,
    input  logic       rst_active,
    input  logic       wdi,
    output logic       wd_fault,
    output logic       fault_early,
    output logic       fault_late
);
    win_lim_t lim_w;
    age_t     age_w;
    logic     tick_w;
    logic     fall_w;
    logic     restart_w;
    logic     armed_w;
    logic     clr_w;

    assign lim_w = win_limits(opt_sel);
    assign clr_w = rst_active | restart_w;

    wdw_edge_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_CYC   (FILT_CYC)
    ) u_filter (
        .clk     (clk),
        .rst     (rst),
        .din     (wdi),
        .fall_evt(fall_w)
    );

    wdw_tick_timer #(
        .TICK_DIV(TICK_DIV)
    ) u_timer (
        .clk (clk),
        .rst (rst),
        .clr (clr_w),
        .tick(tick_w),
        .age (age_w)
    );

    wdw_window_judge u_judge (
        .clk        (clk),
        .rst        (rst),
        .hold       (rst_active),
        .fall_evt   (fall_w),
        .tick       (tick_w),
        .age        (age_w),
        .lim        (lim_w),
        .restart    (restart_w),
        .armed      (armed_w),
        .fault_early(fault_early),
        .fault_late (fault_late),
        .wd_fault   (wd_fault)
    );

endmodule

// File: rtl/wdw_supervisor_chk.sv
`timescale 1ns / 1ps
module wdw_supervisor_chk
    import wdw_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     rst_active,
    input logic     wd_fault,
    input logic     fault_early,
    input logic     fault_late,
    input logic     armed,
    input age_t     age,
    input win_lim_t lim
);
    assert_kind_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(fault_early && fault_late));

    assert_quiet_in_hold_R7: assert property (@(posedge clk) disable iff (rst)
        rst_active |=> !wd_fault);

    assert_timer_held_R7: assert property (@(posedge clk) disable iff (rst)
        rst_active |=> (age == '0));

    assert_hold_disarms_R8: assert property (@(posedge clk) disable iff (rst)
        rst_active |=> !armed);

    assert_early_needs_arm_R8: assert property (@(posedge clk) disable iff (rst)
        fault_early |-> $past(armed));

    assert_age_bound_R6: assert property (@(posedge clk) disable iff (rst)
        age < lim.late_lim);

endmodule

bind wdw_supervisor wdw_supervisor_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .rst_active (rst_active),
    .wd_fault   (wd_fault),
    .fault_early(fault_early),
    .fault_late (fault_late),
    .armed      (armed_w),
    .age        (age_w),
    .lim        (lim_w)
);

// File: tb/test_wdw_supervisor.sv
`timescale 1ns / 1ps
module test_wdw_supervisor;

    localparam int TB_DIV = 40;
    localparam int NVEC   = 13;

    typedef struct packed {
        logic [2:0]  opt;
        logic [15:0] gap;
        logic        exp_early;
        logic        exp_late;
    } vec_t;

    // Limits at TB_DIV=40: opt0 early 120 / late 800, opt1 1200 / 8000, opt5 1920 / 3520 cycles.
    localparam vec_t VEC [NVEC] = '{
        '{3'd0, 16'd100,  1'b1, 1'b0},
        '{3'd0, 16'd120,  1'b1, 1'b0},
        '{3'd0, 16'd121,  1'b0, 1'b0},
        '{3'd0, 16'd400,  1'b0, 1'b0},
        '{3'd0, 16'd800,  1'b0, 1'b0},
        '{3'd0, 16'd1000, 1'b0, 1'b1},
        '{3'd5, 16'd1920, 1'b1, 1'b0},
        '{3'd5, 16'd1921, 1'b0, 1'b0},
        '{3'd5, 16'd3520, 1'b0, 1'b0},
        '{3'd5, 16'd3600, 1'b1, 1'b1},
        '{3'd1, 16'd1200, 1'b1, 1'b0},
        '{3'd1, 16'd5000, 1'b0, 1'b0},
        '{3'd0, 16'd70,   1'b1, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] opt_sel = 3'd0;
    logic       rst_active = 1'b1;
    logic       wdi = 1'b1;
    logic       wd_fault;
    logic       fault_early;
    logic       fault_late;

    int checks = 0;
    int miscompares = 0;
    int n_early = 0;
    int n_late = 0;
    int n_fault = 0;
    int se = 0;
    int sl = 0;
    int sf = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wdw_supervisor #(
        .TICK_DIV(TB_DIV)
    ) i_wdw_supervisor (
        .clk        (clk),
        .rst        (rst),
        .opt_sel    (opt_sel),
        .rst_active (rst_active),
        .wdi        (wdi),
        .wd_fault   (wd_fault),
        .fault_early(fault_early),
        .fault_late (fault_late)
    );

    always @(negedge clk) begin
        if (fault_early) n_early++;
        if (fault_late)  n_late++;
        if (wd_fault)    n_fault++;
    end

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fall_pulse(input int low_cyc);
        wdi = 1'b0;
        idle(low_cyc);
        wdi = 1'b1;
    endtask

    task automatic snap();
        #1;
        se = n_early;
        sl = n_late;
        sf = n_fault;
    endtask

    task automatic rearm(input logic [2:0] opt);
        rst_active = 1'b1;
        idle(10);
        opt_sel = opt;
        idle(70);
        rst_active = 1'b0;
        idle(5);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(5);
        // R1: outputs quiet under reset
        check("R1 wd_fault in reset", int'(wd_fault), 0);
        check("R1 fault_early in reset", int'(fault_early), 0);
        check("R1 fault_late in reset", int'(fault_late), 0);
        rst = 1'b0;
        idle(3);

        // Vector table: arm with one edge, second edge after gap
        for (int i = 0; i < NVEC; i++) begin
            string tag;
            int de;
            int dl;
            tag = VEC[i].exp_late ? "R6 R9" : (VEC[i].exp_early ? "R4 R9" : "R5 R9");
            rearm(VEC[i].opt);
            snap();
            fall_pulse(40);
            idle(int'(VEC[i].gap) - 40);
            fall_pulse(40);
            idle(80);
            #1;
            de = n_early - se;
            dl = n_late - sl;
            check($sformatf("%s vec%0d early count", tag, i), de, int'(VEC[i].exp_early));
            check($sformatf("%s vec%0d late count", tag, i), dl, int'(VEC[i].exp_late));
        end

        // R7 / R6 / R10: exact late fault timing from release and repeat
        rst_active = 1'b1;
        idle(10);
        opt_sel = 3'd0;
        idle(20);
        rst_active = 1'b0;
        idle(799);
        check("R7 no late before limit", int'(fault_late), 0);
        idle(1);
        check("R7 late at limit after release", int'(fault_late), 1);
        check("R10 wd_fault with late", int'(wd_fault), 1);
        check("R10 early low on late", int'(fault_early), 0);
        idle(1);
        check("R10 late pulse one cycle", int'(fault_late), 0);
        idle(798);
        check("R6 no repeat before period", int'(fault_late), 0);
        idle(1);
        check("R6 late repeats after period", int'(fault_late), 1);

        // R7 / R8: edges during hold discarded, first edge after release exempt
        rst_active = 1'b1;
        idle(10);
        snap();
        for (int k = 0; k < 3; k++) begin
            fall_pulse(40);
            idle(40);
        end
        idle(2000);
        #1;
        check("R7 no fault during hold", n_fault - sf, 0);
        rst_active = 1'b0;
        idle(5);
        snap();
        fall_pulse(40);
        idle(60);
        #1;
        check("R8 first edge after release exempt", n_early - se, 0);
        fall_pulse(40);
        idle(80);
        #1;
        check("R4 second edge early", n_early - se, 1);

        // R3: glitch rejection and minimum accepted width (opt 1, early 1200)
        rearm(3'd1);
        fall_pulse(40);
        idle(60);
        snap();
        fall_pulse(29);
        idle(100);
        #1;
        check("R3 short pulse ignored", n_early - se, 0);
        idle(71);
        snap();
        fall_pulse(30);
        idle(80);
        #1;
        check("R3 min width pulse seen", n_early - se, 1);

        // R2: rising edge has no effect
        rearm(3'd0);
        snap();
        wdi = 1'b0;
        idle(60);
        wdi = 1'b1;
        idle(100);
        #1;
        check("R2 rising edge no early", n_early - se, 0);
        check("R2 rising edge no late", n_late - sl, 0);

        // R1: system reset disarms
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(3);
        snap();
        fall_pulse(40);
        idle(60);
        #1;
        check("R1 first edge after rst exempt", n_early - se, 0);
        fall_pulse(40);
        idle(80);
        #1;
        check("R4 armed after rst edge", n_early - se, 1);

        finish_run();
    end

endmodule